// File: doc/BRIEF.md
# Modulo-3 Running-Sum Accumulator

This block keeps a running total of 2-bit operands, reduced modulo 3. On every clock edge where the accept input is high, the operand is added to the stored residue and the remainder after division by 3 replaces it. The stored residue starts at 0 and is presented directly on a 2-bit output. Because that output comes from the register, it reflects every operand accepted up to and including the previous edge.

A synchronous clear returns the residue to 0 and takes priority over an accepted operand in the same cycle. An operand of 3 is congruent to 0, so accepting it leaves the total unchanged. The register therefore only ever holds the codes 0, 1 and 2; code 3 never appears.

Top module: `mod3_accum`

## Requirements
- R1: When `clr` is high at a rising edge of `clk`, `total` reads 0 after that edge.
- R2: When `clr` and `acc_en` are both high at the same edge, the clear wins and `total` becomes 0.
- R3: When `clr` is low and `acc_en` is high at an edge, `total` after the edge equals (previous `total` + `opnd`) mod 3.
- R4: An accepted `opnd` of 3 leaves `total` equal to its value before the edge.
- R5: When `clr` and `acc_en` are both low at an edge, `total` keeps its value whatever `opnd` holds.
- R6: Once cleared, `total` never shows the code 3.
- R7: `total` is a registered value: a change on `opnd`, `acc_en` or `clr` between edges does not change `total` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of the residue, active high |
| acc_en | input | 1 | Accept `opnd` at this edge, active high |
| opnd | input | 2 | Operand, values 0 to 3 |
| total | output | 2 | Stored residue, values 0 to 2 |

## Verification
The clear and an accepted operand can meet in one edge, and the bench sets up every stored residue (0, 1, 2) and then applies every operand with both controls high together. In that case `total` must read 0, not the sum, after the edge. The same sweep also covers each control alone and neither. Each result is judged against residue arithmetic worked out in the bench.

// File: rtl/mod3_pkg.sv
package mod3_pkg;
  localparam int RES_W = 2;
  typedef logic [RES_W-1:0] res_t;

  // Sum of two residues (each 0..2), reduced once.
  function automatic res_t res_add(input res_t a, input res_t b);
    logic [RES_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[RES_W-1:0];
  endfunction
endpackage

// File: rtl/mod3_fold.sv
module mod3_fold #(
  parameter int OPND_W = 2
) (
  input  logic [OPND_W-1:0] raw,
  output mod3_pkg::res_t    res,
  output logic              is_zero_class
);
  localparam int EXT_W = OPND_W + 2;
  logic [EXT_W-1:0] rem;

  always_comb begin
    rem = EXT_W'(raw) % EXT_W'(3);
    res = rem[1:0];
    is_zero_class = (rem == '0);
  end
endmodule

// File: rtl/mod3_step.sv
module mod3_step (
  input  mod3_pkg::res_t cur,
  input  mod3_pkg::res_t addend,
  input  logic           clr,
  input  logic           acc_en,
  output mod3_pkg::res_t nxt,
  output logic           clr_hit,
  output logic           acc_fire,
  output logic           wrap_evt
);
  import mod3_pkg::*;
  res_t sum;

  always_comb begin
    sum      = res_add(cur, addend);
    clr_hit  = clr;
    acc_fire = acc_en && !clr;
    wrap_evt = acc_fire && (({1'b0, cur} + {1'b0, addend}) >= 3'd3);
    if (clr_hit)       nxt = '0;
    else if (acc_fire) nxt = sum;
    else               nxt = cur;
  end
endmodule

// File: rtl/mod3_store.sv
module mod3_store (
  input  logic           clk,
  input  mod3_pkg::res_t d,
  output mod3_pkg::res_t q
);
  always_ff @(posedge clk) q <= d;
endmodule

// File: rtl/mod3_accum.sv
module mod3_accum #(
  parameter int OPND_W = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              acc_en,
  input  logic [OPND_W-1:0] opnd,
  output logic [1:0]        total
);
  import mod3_pkg::*;

  res_t opnd_res;
  logic opnd_null;
  res_t state_q;
  res_t state_d;
  logic clr_hit;
  logic acc_fire;
  logic wrap_evt;

  mod3_fold #(.OPND_W(OPND_W)) u_fold (
    .raw(opnd), .res(opnd_res), .is_zero_class(opnd_null)
  );

  mod3_step u_step (
    .cur(state_q), .addend(opnd_res), .clr(clr), .acc_en(acc_en),
    .nxt(state_d), .clr_hit(clr_hit), .acc_fire(acc_fire), .wrap_evt(wrap_evt)
  );

  mod3_store u_store (.clk(clk), .d(state_d), .q(state_q));

  assign total = state_q;
endmodule

// File: rtl/mod3_accum_chk.sv
module mod3_accum_chk #(
  parameter int OPND_W = 2
) (
  input logic              clk,
  input logic              clr,
  input logic              acc_en,
  input logic [OPND_W-1:0] opnd,
  input logic [1:0]        total,
  input logic              acc_fire,
  input logic              opnd_null
);
  // R1
  clear_to_zero_chk: assert property (@(posedge clk) clr |=> total == 2'd0);

  // R2
  clear_beats_accept_chk: assert property (@(posedge clk) (clr && acc_en) |=> total == 2'd0);

  // R3
  residue_step_chk: assert property (@(posedge clk) disable iff (clr)
    acc_fire |=> total == 2'((({2'b00, $past(total)} + 4'($past(opnd))) % 4'd3)));

  // R4
  zero_class_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (acc_fire && opnd_null) |=> $stable(total));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr)
    (!acc_en) |=> $stable(total));

  // R6
  no_code3_chk: assert property (@(posedge clk) disable iff (clr) total != 2'd3);
endmodule

bind mod3_accum mod3_accum_chk #(.OPND_W(OPND_W)) u_chk (
  .clk(clk), .clr(clr), .acc_en(acc_en), .opnd(opnd), .total(total),
  .acc_fire(acc_fire), .opnd_null(opnd_null)
);

// File: tb/tb_mod3_accum.sv
module tb_mod3_accum;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clr;
  logic       acc_en;
  logic [1:0] opnd;
  logic [1:0] total;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  mod3_accum dut (.clk(clk), .clr(clr), .acc_en(acc_en), .opnd(opnd), .total(total));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: total=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic preload(input int v);
    clr = 1'b1; acc_en = 1'b0; opnd = 2'd0;
    @(negedge clk);
    clr = 1'b0; acc_en = 1'b1; opnd = 2'(v);
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  initial begin
    clr = 1'b1; acc_en = 1'b1; opnd = 2'd2;
    @(negedge clk);
    @(negedge clk);
    check("R1", total, 0);
    for (int s = 0; s < 3; s++) begin
      for (int o = 0; o < 4; o++) begin
        for (int e = 0; e < 2; e++) begin
          for (int c = 0; c < 2; c++) begin
            int exp;
            string tag;
            preload(s);
            check("R3", total, s);
            clr = c[0]; acc_en = e[0]; opnd = 2'(o);
            #1;
            check("R7", total, s);
            if (c == 1) exp = 0;
            else if (e == 1) exp = (s + o) % 3;
            else exp = s;
            if (c == 1 && e == 1) tag = "R2";
            else if (c == 1) tag = "R1";
            else if (e == 1 && o == 3) tag = "R4";
            else if (e == 1) tag = "R3";
            else tag = "R5";
            @(negedge clk);
            check(tag, total, exp);
            check("R6", int'(total == 2'd3), 0);
          end
        end
      end
    end
    // long accumulation run with a software residue
    begin
      int model = 0;
      preload(0);
      for (int i = 0; i < 40; i++) begin
        int v = (i * 7 + 3) % 4;
        clr = 1'b0; acc_en = (i % 5) != 2; opnd = 2'(v);
        if (acc_en) model = (model + v) % 3;
        @(negedge clk);
        check("R3", total, model);
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: total=%0d expected=done", total);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule